// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block is a purely combinational signed multiplier. Two two's-complement operands of `WIDTH` bits (eight by default) go in, and a `2*WIDTH`-bit product comes out in the same cycle. A control slice recodes the multiplier operand into radix-4 digits. Each digit is drawn from the set {-2, -1, 0, +1, +2}. For each digit, the control slice issues a small set of select strobes: zero, double and negate.

A datapath slice uses these strobes to build one partial product per digit from the multiplicand. Each partial product is sign-extended to full width and weighted by a power of four. A negated row is formed as an inverted row plus a single correction bit. The rows and the correction bits then pass through a chain of full-width carry-save stages. The chain leaves a redundant pair of vectors, and one carry-propagate adder resolves that pair into the product.

Both redundant vectors are brought out, so the intermediate result can be observed. Either vector may look negative on its own. Only their sum carries meaning.

Top module: `booth_mul8`

## Requirements
- R1: `product` equals the signed product of `multiplicand` and `multiplier`, both taken as two's-complement values, with the result written as a 16-bit two's-complement value.
- R2: `sumVec + carryVec`, taken modulo 2^16, equals `product` for every input pair.
- R3: Recoding uses four digits. Digit i reads the multiplier bits (2i+1, 2i, 2i-1), where bit -1 reads as 0. The bit pattern (high, mid, low) maps to a digit value as follows: 000 → 0, 111 → 0, 001 → +1, 010 → +1, 011 → +2, 100 → -2, 101 → -1, 110 → -1. Partial product i is the digit value times the multiplicand, weighted by 4^i.
- R4: A digit of value 0 contributes nothing. A multiplier of 0 gives a product of 0. A multiplier of -1 (all ones) gives the negated multiplicand.
- R5: Digits of ±2 and of negative value give correct products. One case is a multiplier of 2, which uses -2 at digit 0 and +1 at digit 1. Another is a multiplier of 0x55, which uses +1 at every digit. A third is a multiplier of 0xAA, which uses -2 at digit 0 and -1 at the higher digits.
- R6: The corner operands give correct products: -128 × -128 = 16384, -128 × 127 = -16256 and 127 × 127 = 16129.
- R7: 10 × 5 gives 50, and 26 × 93 gives 2418.
- R8: All 65536 operand pairs meet R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| multiplicand | input | 8 | Signed multiplicand operand |
| multiplier | input | 8 | Signed multiplier operand, which is Booth-recoded |
| product | output | 16 | Signed product |
| sumVec | output | 16 | Redundant sum vector taken before the final add |
| carryVec | output | 16 | Redundant carry vector taken before the final add, already aligned |

## Verification
Whenever the inputs change, the embedded assertions check several things. They check that every recoded digit decodes to the signed value of its three-bit window. They check that zero digits give an empty row, and that each negated row plus its correction bit equals the negative of its multiple. They also check the final product against a signed reference, and check that the aligned carry vector has a clear bottom bit. Only the bench scenarios can show that the observed redundant pair actually sums to the product at the ports. The same holds for the named worked examples and corner operands, and for complete coverage of all 65536 operand pairs.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
  // per-digit select strobes from the recoder to the datapath
  typedef struct packed {
    logic isZero;
    logic isDouble;
    logic isNeg;
  } boothSel_t;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]                            multiplier,
  output booth_mul_pkg::boothSel_t [WIDTH/2-1:0]      sel
);
  localparam int NPP = WIDTH / 2;

  for (genvar i = 0; i < NPP; i++) begin : gDigit
    logic [2:0] win;
    if (i == 0) begin : gLow
      assign win = {multiplier[1], multiplier[0], 1'b0};
    end else begin : gHigh
      assign win = multiplier[2*i+1 -: 3];
    end

    // R3 encoding
    assign sel[i].isZero   = (win == 3'b000) || (win == 3'b111);
    assign sel[i].isDouble = (win == 3'b011) || (win == 3'b100);
    assign sel[i].isNeg    = win[2] & ~(win[1] & win[0]);

    int winVal;
    int selVal;
    always_comb begin
      winVal = (win[1] ? 1 : 0) + (win[0] ? 1 : 0) - (win[2] ? 2 : 0);
      selVal = sel[i].isZero ? 0 : (sel[i].isDouble ? 2 : 1);
      if (sel[i].isNeg) selVal = -selVal;
      assert_window_decode_R3: assert (selVal == winVal);
    end
  end
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]                       multiplicand,
  input  booth_mul_pkg::boothSel_t [WIDTH/2-1:0] sel,
  output logic [2*WIDTH-1:0]                     sumVec,
  output logic [2*WIDTH-1:0]                     carryVec,
  output logic [2*WIDTH-1:0]                     product
);
  localparam int PW   = 2 * WIDTH;
  localparam int NPP  = WIDTH / 2;
  localparam int NROW = NPP + 1;

  logic [PW-1:0]  rows [NROW];
  logic [PW-1:0]  corrVec;
  logic [WIDTH:0] mExt;

  assign mExt = {multiplicand[WIDTH-1], multiplicand};

  for (genvar i = 0; i < NPP; i++) begin : gRow
    logic [WIDTH:0] mag;
    logic [WIDTH:0] pick;
    logic [PW-1:0]  magWide;
    logic [PW-1:0]  ext;

    assign mag     = sel[i].isDouble ? {multiplicand, 1'b0} : mExt;
    assign pick    = sel[i].isZero ? '0 : (sel[i].isNeg ? ~mag : mag);
    assign ext     = {{(PW-WIDTH-1){pick[WIDTH]}}, pick};
    assign magWide = {{(PW-WIDTH-1){mag[WIDTH]}}, mag};
    assign rows[i] = ext << (2*i);

    always_comb begin
      if (sel[i].isZero) begin
        assert_zero_row_R4: assert (rows[i] == '0);
      end
      if (sel[i].isNeg && !sel[i].isZero) begin
        assert_neg_row_R5: assert (PW'(rows[i] + (PW'(1) << (2*i))) ==
                                   PW'(PW'(0) - (magWide << (2*i))));
      end
    end
  end

  // correction ones for negated rows, one per digit at its LSB
  always_comb begin
    corrVec = '0;
    for (int i = 0; i < NPP; i++) corrVec[2*i] = sel[i].isNeg;
  end
  assign rows[NPP] = corrVec;

  // linear carry-save chain
  logic [PW-1:0] sAcc [1:NROW-1];
  logic [PW-1:0] cAcc [1:NROW-1];
  assign sAcc[1] = rows[0];
  assign cAcc[1] = rows[1];
  for (genvar k = 2; k < NROW; k++) begin : gCsa
    assign sAcc[k] = sAcc[k-1] ^ cAcc[k-1] ^ rows[k];
    assign cAcc[k] = ((sAcc[k-1] & cAcc[k-1]) | (sAcc[k-1] & rows[k]) |
                      (cAcc[k-1] & rows[k])) << 1;
  end

  assign sumVec   = sAcc[NROW-1];
  assign carryVec = cAcc[NROW-1];
  assign product  = sumVec + carryVec;
endmodule

// File: rtl/booth_mul8.sv
module booth_mul8 #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic [2*WIDTH-1:0] sumVec,
  output logic [2*WIDTH-1:0] carryVec
);
  localparam int PW = 2 * WIDTH;

  booth_mul_pkg::boothSel_t [WIDTH/2-1:0] sel;

  booth_recoder #(.WIDTH(WIDTH)) uRecoder (
    .multiplier (multiplier),
    .sel        (sel)
  );

  booth_datapath #(.WIDTH(WIDTH)) uDatapath (
    .multiplicand (multiplicand),
    .sel          (sel),
    .sumVec       (sumVec),
    .carryVec     (carryVec),
    .product      (product)
  );

  logic signed [PW-1:0] refProd;
  assign refProd = $signed(multiplicand) * $signed(multiplier);

  always_comb begin
    assert_product_R1: assert (product == refProd);
    assert_carry_lsb_R2: assert (carryVec[0] == 1'b0);
    if (multiplier == '0) begin
      assert_zero_operand_R4: assert (product == '0);
    end
  end
endmodule

// File: tb/booth_mul8_test.sv
module booth_mul8_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0]  multiplicand, multiplier;
  logic [15:0] product, sumVec, carryVec;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  booth_mul8 uut (
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .sumVec       (sumVec),
    .carryVec     (carryVec)
  );

  task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: a=%0d b=%0d actual=%h expected=%h", req,
               $signed(multiplicand), $signed(multiplier), act, exp);
    end
  endtask

  task automatic applyPair(input logic [7:0] a, input logic [7:0] b, input string req);
    int expVal;
    multiplicand = a;
    multiplier   = b;
    #1;
    expVal = $signed(a) * $signed(b);
    check16(product, 16'(expVal), req);
    check16(16'(sumVec + carryVec), 16'(expVal), "R2");
  endtask

  task automatic testReset();
    applyPair(8'd0, 8'd0, "R4");
  endtask

  task automatic testExamples();
    applyPair(8'd5, 8'd10, "R7");
    applyPair(8'd26, 8'd93, "R7");
    check16(product, 16'd2418, "R7");
  endtask

  task automatic testZeroDigits();
    applyPair(8'd77, 8'h00, "R4");
    applyPair(8'd77, 8'hFF, "R4");
    check16(product, 16'hFFB3, "R4");
    applyPair(8'h80, 8'hFF, "R4");
  endtask

  task automatic testDoubles();
    applyPair(8'd45, 8'd2, "R5");
    applyPair(8'hC3, 8'h55, "R5");
    applyPair(8'd19, 8'hAA, "R5");
    applyPair(8'd7, 8'h03, "R3");
    applyPair(8'hF9, 8'h64, "R3");
  endtask

  task automatic testExtremes();
    applyPair(8'h80, 8'h80, "R6");
    check16(product, 16'd16384, "R6");
    applyPair(8'h80, 8'h7F, "R6");
    check16(product, 16'(-16256), "R6");
    applyPair(8'h7F, 8'h7F, "R6");
    check16(product, 16'd16129, "R6");
  endtask

  task automatic testExhaustive();
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        applyPair(8'(a), 8'(b), "R8");
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    multiplicand = '0;
    multiplier   = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    testReset();
    testExamples();
    testZeroDigits();
    testDoubles();
    testExtremes();
    testExhaustive();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule